// File: doc/BRIEF.md
# Quad DAC Serial Control Frontend

This block is the digital front end of a four-channel, 8-bit voltage-output converter. A host shifts 16-bit command words in over a four-wire serial port: a serial clock, a data line, an active-low chip select and a frame-sync strobe. All four lines, along with the active-low load strobe and the active-low hardware power-down pin, are taken through two-flop synchronizers into a faster system clock. Edges are then detected in that clock domain. The serial clock must run at no more than one quarter of the system clock rate.

Each accepted word carries a two-bit channel address, a power-down bit, a fast/slow settling bit and an 8-bit code. The word lands in the input latch of the addressed channel. It moves on to that channel's output register, which drives the analog core, only while the load strobe is low. While the strobe is held high, writes wait in the input latches and then move together. The hardware power-down pin overrides every channel's own power bit. A sticky flag records any word whose four trailing bits were not zero.

Top module: `qdac_serial_front`

## Requirements
- R1: After reset every output code, fast bit, power-down output and the format flag read 0.
- R2: Chip select high disables the port. A frame-sync falling edge seen while it is high starts nothing. Raising chip select before a frame is committed discards that frame.
- R3: Data is sampled on serial clock falling edges, MSB first. The sixteenth bit commits the word at once, even if frame sync is still low. This covers a host that sends two bytes after one frame-sync falling edge.
- R4: Word layout: bits 15:14 = channel (0..3 selects channel 0..3), bit 13 = power-down (1 = off), bit 12 = speed (1 = fast), bits 11:4 = code. Channel k appears at ch_code_o[8k+7:8k], ch_fast_o[k] and ch_pwrdn_o[k].
- R5: A frame-sync rise after 8 to 15 bits commits the received bits left-aligned as the word's upper bits, with the missing low bits taken as 0. A rise after fewer than 8 bits discards the frame.
- R6: Bits clocked in after the sixteenth are ignored until the next frame-sync falling edge.
- R7: While the load strobe is high, the output code and speed bits do not change. Once it is seen low, every channel holding a pending write updates in the same cycle.
- R8: While the power-down pin is low, every ch_pwrdn_o bit is 1 and the codes are kept. Releasing the pin restores each channel's own power bit.
- R9: A committed word with nonzero bits 3:0 sets fmt_err_o, which stays set until reset. The code in that word is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| din_i | input | 1 | Serial data |
| cs_n_i | input | 1 | Chip select, active low |
| fs_i | input | 1 | Frame sync; a falling edge opens a frame |
| ldac_n_i | input | 1 | Load strobe, active low |
| pd_n_i | input | 1 | Hardware power-down, active low |
| ch_code_o | output | 32 | Per-channel output codes, channel k at [8k+7:8k] |
| ch_fast_o | output | 4 | Per-channel fast settling select |
| ch_pwrdn_o | output | 4 | Per-channel power-down to the analog core |
| fmt_err_o | output | 1 | Sticky flag for nonzero trailing bits |

## Verification
The assertions assume the serial clock is at least four system clocks per period. They also assume data does not change near a falling serial clock edge, and that frame sync never moves in the same system cycle as a serial clock edge. The stimulus meets these assumptions by holding every serial level for four system clocks. It changes data only while the serial clock is high, and it moves frame sync and chip select only while the serial clock is idle.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int QD_NCH    = 4;
  localparam int QD_CODE_W = 8;
  localparam int QD_WORD_W = 16;
  localparam int QD_ADDR_W = $clog2(QD_NCH);
  localparam int QD_PAD_W  = QD_WORD_W - QD_ADDR_W - 2 - QD_CODE_W;
  localparam int QD_CNT_W  = $clog2(QD_WORD_W + 1);

  // Field order is fixed by the serial word: address, power, speed, code, pad.
  typedef struct packed {
    logic [QD_ADDR_W-1:0] addr;
    logic                 pwr;
    logic                 fast;
    logic [QD_CODE_W-1:0] code;
    logic [QD_PAD_W-1:0]  pad;
  } qd_word_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/qdac_deser.sv
module qdac_deser
  import qdac_pkg::*;
#(
  parameter int MIN_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk_s,
  input  logic                 fs_s,
  input  logic                 cs_n_s,
  input  logic                 din_s,
  output logic                 commit_o,
  output logic [QD_WORD_W-1:0] word_o,
  output logic [QD_CNT_W-1:0]  cnt_o
);
  localparam logic [QD_CNT_W-1:0] LAST_IDX = QD_CNT_W'(QD_WORD_W - 1);
  localparam logic [QD_CNT_W-1:0] FULL_CNT = QD_CNT_W'(QD_WORD_W);
  localparam logic [QD_CNT_W-1:0] MIN_CNT  = QD_CNT_W'(MIN_BITS);

  logic                 sclk_d, fs_d;
  logic                 active;
  logic [QD_CNT_W-1:0]  cnt;
  logic [QD_WORD_W-1:0] shreg;
  logic [QD_WORD_W-1:0] shifted;
  logic                 sclk_fall, fs_fall, fs_rise;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign fs_fall   = fs_d & ~fs_s;
  assign fs_rise   = ~fs_d & fs_s;
  assign shifted   = {shreg[QD_WORD_W-2:0], din_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b1;
      fs_d     <= 1'b1;
      active   <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      word_o   <= '0;
      commit_o <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      fs_d     <= fs_s;
      commit_o <= 1'b0;
      if (cs_n_s) begin
        active <= 1'b0;
      end else if (fs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
        shreg  <= '0;
      end else if (active) begin
        if (sclk_fall) begin
          shreg <= shifted;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST_IDX) begin
            word_o   <= shifted;
            commit_o <= 1'b1;
            active   <= 1'b0;
          end
        end else if (fs_rise) begin
          active <= 1'b0;
          if (cnt >= MIN_CNT) begin
            word_o   <= shreg << (FULL_CNT - cnt);
            commit_o <= 1'b1;
          end
        end
      end
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
  import qdac_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  qd_word_t                    wr_word,
  input  logic                        ldac_low,
  input  logic                        pd_low,
  output logic [QD_NCH*QD_CODE_W-1:0] code_o,
  output logic [QD_NCH-1:0]           fast_o,
  output logic [QD_NCH-1:0]           pwrdn_o,
  output logic                        fmt_err_o
);
  for (genvar g = 0; g < QD_NCH; g++) begin : g_ch
    logic [QD_CODE_W-1:0] in_code, out_code;
    logic                 in_fast, out_fast, in_pwr, out_pwr;
    logic                 pend, pwrdn_q, hit;

    assign hit = wr_en && (wr_word.addr == QD_ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        in_code  <= '0;
        in_fast  <= 1'b0;
        in_pwr   <= 1'b0;
        out_code <= '0;
        out_fast <= 1'b0;
        out_pwr  <= 1'b0;
        pend     <= 1'b0;
        pwrdn_q  <= 1'b0;
      end else begin
        if (hit) begin
          in_code <= wr_word.code;
          in_fast <= wr_word.fast;
          in_pwr  <= wr_word.pwr;
        end
        pend <= hit | (pend & ~ldac_low);
        if (pend && ldac_low) begin
          out_code <= in_code;
          out_fast <= in_fast;
          out_pwr  <= in_pwr;
        end
        pwrdn_q <= out_pwr | pd_low;
      end
    end

    assign code_o[g*QD_CODE_W +: QD_CODE_W] = out_code;
    assign fast_o[g]  = out_fast;
    assign pwrdn_o[g] = pwrdn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) fmt_err_o <= 1'b0;
    else if (wr_en && (wr_word.pad != '0)) fmt_err_o <= 1'b1;
  end
endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_BITS    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sclk_i,
  input  logic                        din_i,
  input  logic                        cs_n_i,
  input  logic                        fs_i,
  input  logic                        ldac_n_i,
  input  logic                        pd_n_i,
  output logic [QD_NCH*QD_CODE_W-1:0] ch_code_o,
  output logic [QD_NCH-1:0]           ch_fast_o,
  output logic [QD_NCH-1:0]           ch_pwrdn_o,
  output logic                        fmt_err_o
);
  // Synchronizer lane order: {pd_n, ldac_n, din, cs_n, fs, sclk}
  logic [5:0]           raw_in, syn;
  logic                 ldac_low_s, pd_low_s, cs_high_s;
  logic                 frm_commit;
  logic [QD_WORD_W-1:0] frm_word;
  logic [QD_CNT_W-1:0]  rx_cnt;

  assign raw_in = {pd_n_i, ldac_n_i, din_i, cs_n_i, fs_i, sclk_i};

  qdac_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b110111)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  assign cs_high_s  = syn[2];
  assign ldac_low_s = ~syn[4];
  assign pd_low_s   = ~syn[5];

  qdac_deser #(.MIN_BITS(MIN_BITS)) u_deser (
    .clk(clk), .rst(rst),
    .sclk_s(syn[0]), .fs_s(syn[1]), .cs_n_s(syn[2]), .din_s(syn[3]),
    .commit_o(frm_commit), .word_o(frm_word), .cnt_o(rx_cnt)
  );

  qdac_chan_bank u_bank (
    .clk(clk), .rst(rst),
    .wr_en(frm_commit), .wr_word(qd_word_t'(frm_word)),
    .ldac_low(ldac_low_s), .pd_low(pd_low_s),
    .code_o(ch_code_o), .fast_o(ch_fast_o), .pwrdn_o(ch_pwrdn_o),
    .fmt_err_o(fmt_err_o)
  );
endmodule

// File: rtl/qdac_serial_front_chk.sv
module qdac_serial_front_chk
  import qdac_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        ldac_low_s,
  input logic                        pd_low_s,
  input logic                        cs_high_s,
  input logic                        frm_commit,
  input logic [QD_CNT_W-1:0]         rx_cnt,
  input logic [QD_NCH*QD_CODE_W-1:0] ch_code_o,
  input logic [QD_NCH-1:0]           ch_fast_o,
  input logic [QD_NCH-1:0]           ch_pwrdn_o,
  input logic                        fmt_err_o
);
  // R2
  commit_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    frm_commit |-> $past(!cs_high_s));

  // R6
  bit_count_cap_chk: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= QD_CNT_W'(QD_WORD_W));

  // R7
  hold_code_chk: assert property (@(posedge clk) disable iff (rst)
    !ldac_low_s |=> $stable(ch_code_o));

  // R7
  hold_speed_chk: assert property (@(posedge clk) disable iff (rst)
    !ldac_low_s |=> $stable(ch_fast_o));

  // R8
  pd_override_chk: assert property (@(posedge clk) disable iff (rst)
    pd_low_s |=> (ch_pwrdn_o == '1));

  // R9
  fmt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_err_o |=> fmt_err_o);
endmodule

bind qdac_serial_front qdac_serial_front_chk u_chk (
  .clk(clk), .rst(rst), .ldac_low_s(ldac_low_s), .pd_low_s(pd_low_s),
  .cs_high_s(cs_high_s), .frm_commit(frm_commit), .rx_cnt(rx_cnt),
  .ch_code_o(ch_code_o), .ch_fast_o(ch_fast_o), .ch_pwrdn_o(ch_pwrdn_o),
  .fmt_err_o(fmt_err_o)
);

// File: tb/qdac_serial_front_tb.sv
module qdac_serial_front_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, din = 1'b0, cs_n = 1'b1, fs = 1'b1, ldac_n = 1'b0, pd_n = 1'b1;
  logic [31:0] code_o;
  logic [3:0]  fast_o, pwrdn_o;
  logic        fmt_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_in_code [4], m_out_code [4];
  bit   m_in_fast [4], m_out_fast [4], m_in_pwr [4], m_out_pwr [4], m_pend [4];
  bit   m_fmt = 1'b0;

  always #4 clk = ~clk;

  qdac_serial_front u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .din_i(din), .cs_n_i(cs_n), .fs_i(fs),
    .ldac_n_i(ldac_n), .pd_n_i(pd_n), .ch_code_o(code_o), .ch_fast_o(fast_o),
    .ch_pwrdn_o(pwrdn_o), .fmt_err_o(fmt_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_apply();
    for (int c = 0; c < 4; c++) if (m_pend[c]) begin
      m_out_code[c] = m_in_code[c]; m_out_fast[c] = m_in_fast[c];
      m_out_pwr[c] = m_in_pwr[c];   m_pend[c] = 1'b0;
    end
  endtask

  task automatic model_commit(input logic [15:0] w);
    int a = int'(w[15:14]);
    m_in_code[a] = w[11:4]; m_in_fast[a] = w[12]; m_in_pwr[a] = w[13];
    m_pend[a] = 1'b1;
    if (w[3:0] != 4'h0) m_fmt = 1'b1;
    if (!ldac_n) model_apply();
  endtask

  task automatic check(input string req);
    logic [31:0] ec; logic [3:0] ef, ep;
    for (int c = 0; c < 4; c++) begin
      ec[c*8 +: 8] = m_out_code[c]; ef[c] = m_out_fast[c];
      ep[c] = m_out_pwr[c] | !pd_n;
    end
    n_chk++;
    if (code_o !== ec || fast_o !== ef || pwrdn_o !== ep || fmt_o !== m_fmt) begin
      n_fail++;
      $display("FAIL %s: got code=%h fast=%b pd=%b fmt=%b exp code=%h fast=%b pd=%b fmt=%b",
               req, code_o, fast_o, pwrdn_o, fmt_o, ec, ef, ep, m_fmt);
    end
  endtask

  task automatic shift_bits(input logic [15:0] w, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      din = (i < 16) ? w[15-i] : 1'b1;
      tick(4); sclk = 1'b0; tick(4); sclk = 1'b1;
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input bit abort, input bit cs_off);
    if (!cs_off) cs_n = 1'b0;
    tick(4); fs = 1'b0; tick(4);
    shift_bits(w, 0, nbits);
    tick(2);
    if (abort) begin cs_n = 1'b1; tick(6); end
    fs = 1'b1; tick(12); cs_n = 1'b1; tick(4);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_in_code[c] = 0; m_out_code[c] = 0; m_in_fast[c] = 0; m_out_fast[c] = 0;
      m_in_pwr[c] = 0; m_out_pwr[c] = 0; m_pend[c] = 0;
    end
    tick(5); rst = 1'b0; tick(6);
    check("R1 reset state");

    // R3 R4: sweep every channel and control pair with several codes
    for (int ch = 0; ch < 4; ch++)
      for (int ctl = 0; ctl < 4; ctl++)
        for (int k = 0; k < 3; k++) begin
          logic [15:0] w;
          logic [7:0]  cd = 8'((ch * 61 + ctl * 23 + k * 85) & 255);
          w = {2'(ch), 2'(ctl), cd, 4'h0};
          frame(w, 16, 1'b0, 1'b0); model_commit(w);
          check("R4 decode sweep");
        end

    // R5: early frame-sync rise after 12 bits, left-aligned
    frame(16'h6A5F, 12, 1'b0, 1'b0); model_commit(16'h6A50);
    check("R5 early commit 12 bits");
    // R5: fewer than 8 bits discarded
    frame(16'hC3C0, 6, 1'b0, 1'b0);
    check("R5 short frame discarded");

    // R2: chip select rises mid-frame, then whole frame with select high
    frame(16'h8FF0, 10, 1'b1, 1'b0);
    check("R2 aborted frame discarded");
    frame(16'h0110, 16, 1'b0, 1'b1);
    check("R2 select high ignored");

    // R6: extra bits after the sixteenth
    frame(16'hB7E0, 20, 1'b0, 1'b0); model_commit(16'hB7E0);
    check("R6 extra bits ignored");

    // R3: two-byte host, commit on sixteenth bit while frame sync stays low
    cs_n = 1'b0; tick(4); fs = 1'b0; tick(4);
    shift_bits(16'h5420, 0, 8); tick(24);
    shift_bits(16'h5420, 8, 16); tick(12);
    model_commit(16'h5420);
    check("R3 sixteenth-bit commit");
    fs = 1'b1; tick(8); cs_n = 1'b1; tick(4);

    // R7: load strobe high holds outputs, then releases together
    ldac_n = 1'b1; tick(6);
    frame(16'h1230, 16, 1'b0, 1'b0); model_commit(16'h1230);
    frame(16'hE9A0, 16, 1'b0, 1'b0); model_commit(16'hE9A0);
    check("R7 outputs held");
    ldac_n = 1'b0; model_apply(); tick(6);
    check("R7 pending channels released");

    // R8: hardware power-down override and release
    pd_n = 1'b0; tick(6);
    check("R8 all powered down");
    frame(16'h0F00, 16, 1'b0, 1'b0); model_commit(16'h0F00);
    check("R8 codes still written");
    pd_n = 1'b1; tick(6);
    check("R8 released");

    // R9: format error sticky, code still accepted
    frame(16'h4C35, 16, 1'b0, 1'b0); model_commit(16'h4C35);
    check("R9 flag set code accepted");
    frame(16'hC110, 16, 1'b0, 1'b0); model_commit(16'hC110);
    check("R9 flag sticky");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule